// File: doc/BRIEF.md
# SPI Burst Register and RAM Access Slave

This block is the serial front end of a small timekeeping device. An SPI master selects it by pulling chip select low and clocks in a command byte. The command byte sets the direction of the access and a location code. The location code selects either a 96-byte RAM or an 8-entry register bank, together with a starting location in that space. Any number of data bytes may follow while chip select stays low. Each completed data byte advances the location, and the location wraps to zero at the end of the space it started in.

The SPI pins are oversampled by the system clock. SCLK idles high, the slave samples the serial input on rising SCLK, and it changes the serial output after falling SCLK. The storage itself is outside the block and is reached through a single synchronous port. For a read, the port returns data one clock after the request. Every SCLK half period must last at least `SYNC_STAGES + 4` system clocks. A bus-disable input blocks the serial interface during reset or low supply. After bus-disable is released, the block accepts nothing until chip select has been seen high.

Top module: `spi_burst_slave`

## Requirements
- R1: The serial input is sampled on rising SCLK. The serial output changes only after falling SCLK. Every byte is sent most significant bit first.
- R2: In the command byte, bit 7 = 1 requests a read and 0 a write. Bits 6:0 form a location code: 0x00–0x5F address RAM locations 0–95, and 0x60–0x67 address register bank locations 0–7.
- R3: A storage write takes place only after all eight bits of a data byte have arrived. If chip select rises partway through a byte, that partial byte is discarded.
- R4: Within one chip-select-low period, each data byte after the first goes to the location after the one before it, for both reads and writes.
- R5: Burst addressing wraps to location 0 of the same space: after RAM location 95, and after register location 7.
- R6: On a read, the first data bit appears after the falling SCLK edge that follows the last command bit. Later bytes follow without gaps.
- R7: A location code of 0x68–0x7F causes no storage write, and every byte read under it is 0x00.
- R8: `spi_miso_oe` is high only while read data is being shifted out. It is low during the command byte, during writes, and after chip select rises.
- R9: While `bus_off` is high, SCLK and data activity cause no access and `spi_miso_oe` stays low. After `bus_off` is released, a transfer that is already in progress stays ignored until chip select goes high.
- R10: After reset, `spi_miso_oe` and `spi_miso` are low and no storage access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_off | input | 1 | High disables the serial interface |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, low when not driving |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; low means high impedance |
| st_en | output | 1 | Storage access strobe, one clock wide |
| st_we | output | 1 | With `st_en`: 1 = write, 0 = read |
| st_ram | output | 1 | 1 = RAM space, 0 = register bank |
| st_addr | output | 7 | Location within the selected space |
| st_wdata | output | 8 | Write data |
| st_rdata | input | 8 | Read data, valid one clock after a read strobe |

## Verification
Bursts are run through both address spaces. Write-then-read pairs distinguish a correct increment from a stuck or skipped location. Bursts that start near the end of each space show whether wrapping happens at the right location and stays in the right space. A read of untouched RAM checks the path from storage to the serial output against an independently computed fill pattern. A one-position shift in that data would expose an error in the first-bit timing. Three more patterns check the cases where nothing should happen: a partial trailing byte, location codes that fall outside both spaces, and traffic during or straddling `bus_off`.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;
  typedef enum logic [1:0] {SP_NONE, SP_RAM, SP_REG} space_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_off,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic srst_n,
  output logic active,
  output logic rise,
  output logic fall,
  output logic mosi_s
);
  logic [1:0]        rst_pipe;
  logic [STAGES-1:0] cs_pipe, sclk_pipe, mosi_pipe;
  logic              sclk_prev_q, armed_q, armed_d;
  logic              cs_s, sclk_s;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '1;
      mosi_pipe <= '0;
    end else begin
      cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
    end
  end

  assign cs_s   = cs_pipe[STAGES-1];
  assign sclk_s = sclk_pipe[STAGES-1];
  assign mosi_s = mosi_pipe[STAGES-1];

  // re-arm only after chip select is seen high with the bus enabled
  always_comb begin
    armed_d = armed_q;
    if (bus_off)   armed_d = 1'b0;
    else if (cs_s) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sclk_prev_q <= 1'b1;
      armed_q     <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      armed_q     <= armed_d;
    end
  end

  assign active = armed_q & ~cs_s & ~bus_off;
  assign rise   = active & sclk_s & ~sclk_prev_q;
  assign fall   = active & ~sclk_s & sclk_prev_q;

  AST_BUS_OFF_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    bus_off |=> !active || !$past(bus_off) && !bus_off) else $error("bus_off"); // R9
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(rise && fall)) else $error("edge"); // R1
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_burst_pkg::*;
#(
  parameter int RAM_DEPTH = 96,
  parameter int REG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              mosi_s,
  output logic              st_en,
  output logic              st_we,
  output logic              st_ram,
  output logic [ADDR_W-1:0] st_addr,
  output logic [7:0]        st_wdata,
  output logic              rd_mode,
  output logic              ld_req,
  output logic              ld_zero
);
  localparam int REG_BASE = RAM_DEPTH;
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] REG_LAST = ADDR_W'(REG_DEPTH - 1);

  phase_e            ph_q, ph_d;
  space_e            sp_q, sp_d, dec_sp, req_sp;
  logic [ADDR_W-1:0] addr_q, addr_d, dec_addr, nxt_addr, req_addr;
  logic [6:0]        rx_q, rx_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic [7:0]        byte_w;
  logic              req_rd, req_wr;

  assign byte_w = {rx_q, mosi_s};

  // location code decode
  always_comb begin
    dec_sp   = SP_NONE;
    dec_addr = '0;
    if (int'(byte_w[6:0]) < RAM_DEPTH) begin
      dec_sp   = SP_RAM;
      dec_addr = byte_w[6:0];
    end else if (int'(byte_w[6:0]) - REG_BASE < REG_DEPTH) begin
      dec_sp   = SP_REG;
      dec_addr = ADDR_W'(int'(byte_w[6:0]) - REG_BASE);
    end
  end

  // burst increment with wrap inside the current space
  always_comb begin
    unique case (sp_q)
      SP_RAM:  nxt_addr = (addr_q == RAM_LAST) ? '0 : addr_q + 1'b1;
      SP_REG:  nxt_addr = (addr_q == REG_LAST) ? '0 : addr_q + 1'b1;
      default: nxt_addr = '0;
    endcase
  end

  always_comb begin
    ph_d     = ph_q;
    sp_d     = sp_q;
    addr_d   = addr_q;
    rx_d     = rx_q;
    bcnt_d   = bcnt_q;
    req_rd   = 1'b0;
    req_wr   = 1'b0;
    req_sp   = sp_q;
    req_addr = addr_q;
    ld_req   = 1'b0;
    if (!active) begin
      ph_d   = PH_CMD;
      bcnt_d = '0;
    end else if (rise) begin
      rx_d   = byte_w[6:0];
      bcnt_d = bcnt_q + 3'd1;
      if (bcnt_q == 3'd7) begin
        unique case (ph_q)
          PH_CMD: begin
            ph_d   = byte_w[7] ? PH_RD : PH_WR;
            sp_d   = dec_sp;
            addr_d = dec_addr;
            if (byte_w[7]) begin
              ld_req   = 1'b1;
              req_rd   = (dec_sp != SP_NONE);
              req_sp   = dec_sp;
              req_addr = dec_addr;
            end
          end
          PH_WR: begin
            req_wr = (sp_q != SP_NONE);
            addr_d = nxt_addr;
          end
          default: begin
            ld_req   = 1'b1;
            req_rd   = (sp_q != SP_NONE);
            req_addr = nxt_addr;
            addr_d   = nxt_addr;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ph_q   <= PH_CMD;
      sp_q   <= SP_NONE;
      addr_q <= '0;
      rx_q   <= '0;
      bcnt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      sp_q   <= sp_d;
      addr_q <= addr_d;
      rx_q   <= rx_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign st_en    = req_rd | req_wr;
  assign st_we    = req_wr;
  assign st_ram   = (req_sp == SP_RAM);
  assign st_addr  = req_addr;
  assign st_wdata = byte_w;
  assign rd_mode  = (ph_q == PH_RD);
  assign ld_zero  = ld_req & ~req_rd;

  AST_WRITE_IN_WR_PHASE: assert property (@(posedge clk) disable iff (!srst_n)
    st_we |-> ph_q == PH_WR && active) else $error("write phase"); // R3
  AST_ADDR_IN_SPACE: assert property (@(posedge clk) disable iff (!srst_n)
    st_en |-> (st_ram ? int'(st_addr) < RAM_DEPTH : int'(st_addr) < REG_DEPTH))
    else $error("addr range"); // R5
  AST_CMD_NO_ACCESS: assert property (@(posedge clk) disable iff (!srst_n)
    !active |-> !st_en) else $error("idle access"); // R9
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
  input  logic       clk,
  input  logic       srst_n,
  input  logic       active,
  input  logic       fall,
  input  logic       rd_mode,
  input  logic       ld_req,
  input  logic       ld_zero,
  input  logic [7:0] st_rdata,
  output logic       miso,
  output logic       miso_oe
);
  logic       ld_pend_q, ld_zero_q, out_q, oe_q;
  logic       out_d, oe_d;
  logic [7:0] tx_q, tx_d;

  always_comb begin
    tx_d  = tx_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (!active) begin
      oe_d  = 1'b0;
      out_d = 1'b0;
    end else if (ld_pend_q) begin
      tx_d = ld_zero_q ? 8'h00 : st_rdata;
    end else if (fall && rd_mode) begin
      out_d = tx_q[7];
      tx_d  = {tx_q[6:0], 1'b0};
      oe_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ld_pend_q <= 1'b0;
      ld_zero_q <= 1'b0;
      tx_q      <= '0;
      out_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      ld_pend_q <= ld_req;
      ld_zero_q <= ld_zero;
      tx_q      <= tx_d;
      out_q     <= out_d;
      oe_q      <= oe_d;
    end
  end

  assign miso    = out_q & oe_q;
  assign miso_oe = oe_q;

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!srst_n)
    !active |=> !oe_q) else $error("oe drop"); // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    oe_q |-> rd_mode) else $error("oe phase"); // R8
  AST_LOAD_BEFORE_FALL: assert property (@(posedge clk) disable iff (!srst_n)
    ld_pend_q |-> !fall) else $error("sclk too fast"); // R6
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import spi_burst_pkg::*;
#(
  parameter int RAM_DEPTH   = 96,
  parameter int REG_DEPTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_off,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              st_en,
  output logic              st_we,
  output logic              st_ram,
  output logic [ADDR_W-1:0] st_addr,
  output logic [7:0]        st_wdata,
  input  logic [7:0]        st_rdata
);
  logic srst_n, active, rise, fall, mosi_s;
  logic rd_mode, ld_req, ld_zero;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .cs_n(spi_cs_n),
    .sclk(spi_sclk), .mosi(spi_mosi), .srst_n(srst_n), .active(active),
    .rise(rise), .fall(fall), .mosi_s(mosi_s)
  );

  spi_cmd_ctrl #(.RAM_DEPTH(RAM_DEPTH), .REG_DEPTH(REG_DEPTH)) u_ctrl (
    .clk(clk), .srst_n(srst_n), .active(active), .rise(rise),
    .mosi_s(mosi_s), .st_en(st_en), .st_we(st_we), .st_ram(st_ram),
    .st_addr(st_addr), .st_wdata(st_wdata), .rd_mode(rd_mode),
    .ld_req(ld_req), .ld_zero(ld_zero)
  );

  spi_tx_shift u_tx (
    .clk(clk), .srst_n(srst_n), .active(active), .fall(fall),
    .rd_mode(rd_mode), .ld_req(ld_req), .ld_zero(ld_zero),
    .st_rdata(st_rdata), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: tb/spi_burst_slave_tb.sv
`timescale 1ns/1ps
module spi_burst_slave_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n, bus_off, cs_n, sclk, mosi;
  logic       miso, oe, st_en, st_we, st_ram;
  logic [6:0] st_addr;
  logic [7:0] st_wdata, st_rdata;

  logic [7:0] ram  [0:95];
  logic [7:0] regs [0:7];
  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];
  int         wr_cnt, acc_cnt, checks, fails;
  logic       oe_cmd_seen, oe_data_all, oe_any, done;

  always #4 clk = ~clk;

  spi_burst_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe),
    .st_en(st_en), .st_we(st_we), .st_ram(st_ram), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  function automatic logic [8:0] ram_init(input int i);
    return 9'(i * 7 + 3);
  endfunction

  // storage model outside the block
  initial begin
    for (int i = 0; i < 96; i++) ram[i] = ram_init(i)[7:0];
    for (int i = 0; i < 8; i++)  regs[i] = 8'hC0 + 8'(i);
    st_rdata = 8'h00;
    wr_cnt = 0;
    acc_cnt = 0;
  end

  always @(posedge clk) begin
    if (st_en) begin
      acc_cnt <= acc_cnt + 1;
      if (st_we) begin
        wr_cnt <= wr_cnt + 1;
        if (st_ram) ram[int'(st_addr)] <= st_wdata;
        else        regs[int'(st_addr[2:0])] <= st_wdata;
      end else begin
        st_rdata <= st_ram ? ram[int'(st_addr)] : regs[int'(st_addr[2:0])];
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input int nbytes, input int tail_bits);
    oe_cmd_seen = 1'b0;
    oe_data_all = 1'b1;
    oe_any      = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbytes + ((tail_bits > 0) ? 1 : 0); i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (i == nbytes && (7 - b) >= tail_bits) break;
        sclk = 1'b0;
        mosi = tx_buf[i][b];
        repeat (H) @(negedge clk);
        rx_buf[i][b] = miso;
        if (oe) oe_any = 1'b1;
        if (i == 0) begin
          if (oe) oe_cmd_seen = 1'b1;
        end else if (!oe) begin
          oe_data_all = 1'b0;
        end
        sclk = 1'b1;
        repeat (H) @(negedge clk);
      end
    end
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 oe after reset", int'(oe), 0);
    check("R10 miso after reset", int'(miso), 0);
    check("R10 no access after reset", acc_cnt, 0);
  endtask

  task automatic t_ram_burst;
    int w0 = wr_cnt;
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
    spi_xfer(4, 0);
    check("R4 ram[5]", int'(ram[5]), 'h11);
    check("R4 ram[6]", int'(ram[6]), 'h22);
    check("R4 ram[7]", int'(ram[7]), 'h33);
    check("R3 write count", wr_cnt - w0, 3);
    check("R8 oe low in write", int'(oe_any), 0);
    tx_buf[0] = 8'h85;
    spi_xfer(4, 0);
    check("R6 read byte0", int'(rx_buf[1]), 'h11);
    check("R4 read byte1", int'(rx_buf[2]), 'h22);
    check("R4 read byte2", int'(rx_buf[3]), 'h33);
    check("R8 oe low in command", int'(oe_cmd_seen), 0);
    check("R8 oe high in read data", int'(oe_data_all), 1);
    @(negedge clk);
    check("R8 oe low after cs", int'(oe), 0);
    tx_buf[0] = 8'h80 | 8'd40;
    spi_xfer(3, 0);
    check("R1 untouched ram[40]", int'(rx_buf[1]), int'(ram_init(40)[7:0]));
    check("R1 untouched ram[41]", int'(rx_buf[2]), int'(ram_init(41)[7:0]));
  endtask

  task automatic t_reg_wrap;
    tx_buf[0] = 8'h66; tx_buf[1] = 8'hA1; tx_buf[2] = 8'hB2;
    tx_buf[3] = 8'hC3; tx_buf[4] = 8'hD4;
    spi_xfer(5, 0);
    check("R2 reg[6]", int'(regs[6]), 'hA1);
    check("R5 reg[7]", int'(regs[7]), 'hB2);
    check("R5 reg wrap to 0", int'(regs[0]), 'hC3);
    check("R5 reg[1]", int'(regs[1]), 'hD4);
    check("R2 ram[6] untouched", int'(ram[6]), 'h22);
    tx_buf[0] = 8'hE6;
    spi_xfer(6, 0);
    check("R5 read reg[6]", int'(rx_buf[1]), 'hA1);
    check("R5 read reg[0] after wrap", int'(rx_buf[3]), 'hC3);
    check("R5 read reg[2]", int'(rx_buf[5]), 'hC2);
  endtask

  task automatic t_ram_wrap;
    tx_buf[0] = 8'h5E; tx_buf[1] = 8'hE1; tx_buf[2] = 8'hE2; tx_buf[3] = 8'hE3;
    spi_xfer(4, 0);
    check("R5 ram[94]", int'(ram[94]), 'hE1);
    check("R5 ram[95]", int'(ram[95]), 'hE2);
    check("R5 ram wrap to 0", int'(ram[0]), 'hE3);
    tx_buf[0] = 8'hDE;
    spi_xfer(4, 0);
    check("R5 read ram[95]", int'(rx_buf[2]), 'hE2);
    check("R5 read ram[0]", int'(rx_buf[3]), 'hE3);
  endtask

  task automatic t_partial;
    int w0 = wr_cnt;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h5A; tx_buf[2] = 8'hFF;
    spi_xfer(2, 5);
    check("R3 full byte written", int'(ram[16]), 'h5A);
    check("R3 partial byte dropped", int'(ram[17]), int'(ram_init(17)[7:0]));
    check("R3 one write only", wr_cnt - w0, 1);
  endtask

  task automatic t_invalid;
    int w0 = wr_cnt;
    tx_buf[0] = 8'h70; tx_buf[1] = 8'h99; tx_buf[2] = 8'h98;
    spi_xfer(3, 0);
    check("R7 no write for bad code", wr_cnt - w0, 0);
    tx_buf[0] = 8'hF0;
    spi_xfer(3, 0);
    check("R7 bad read byte0", int'(rx_buf[1]), 0);
    check("R7 bad read byte1", int'(rx_buf[2]), 0);
    check("R8 oe driven for bad read", int'(oe_data_all), 1);
    tx_buf[0] = 8'hE8;
    spi_xfer(2, 0);
    check("R7 code 0x68 reads zero", int'(rx_buf[1]), 0);
  endtask

  task automatic t_bus_off;
    int w0 = wr_cnt;
    bus_off = 1'b1;
    tx_buf[0] = 8'h20; tx_buf[1] = 8'h77;
    spi_xfer(2, 0);
    check("R9 no write while off", wr_cnt - w0, 0);
    tx_buf[0] = 8'hA0;
    spi_xfer(2, 0);
    check("R9 oe low while off", int'(oe_any), 0);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_off = 1'b0;
    tx_buf[0] = 8'h21; tx_buf[1] = 8'h66;
    spi_xfer(2, 0);
    check("R9 straddled transfer ignored", wr_cnt - w0, 0);
    check("R9 ram[33] untouched", int'(ram[33]), int'(ram_init(33)[7:0]));
    spi_xfer(2, 0);
    check("R9 transfer after cs high", int'(ram[33]), 'h66);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bus_off = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b1;
    mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_ram_burst();
    t_reg_wrap();
    t_ram_wrap();
    t_partial();
    t_invalid();
    t_bus_off();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule